// File: doc/BRIEF.md
# Multi-Buffer Field Write Address Sequencer

This block turns an incoming stream of video pixel words into memory word addresses spread over a ring of frame buffers. Each field is placed in one buffer slot. A slot's start address is derived from a base address and a per-slot stride. Inside a field, every line begins one line stride past the previous line's start. Within a line, the address steps by one per word. Words past the configured line width, and lines past the configured field height, are accepted but produce no write. A field that is shorter than configured leaves the rest of its buffer untouched.

Three run modes are supported. In the stopped mode no field is written. In free-running mode the ring wraps back to the base after the last slot. In single-shot mode the block fills the ring once and then holds until an acknowledge arrives. When the reuse option is on, a field that ends broken or short does not consume a slot, and the next field lands in the same buffer. A done pulse carries the start address of each completed buffer, and a line pulse carries the zero-based index of each line written, so that a line interrupt can be raised downstream.

The pixel input is valid/ready and the write output is valid/ready. When `wr_valid` is high, `pix_ready` follows `wr_ready`. Otherwise `pix_ready` is high, so discarded words are always taken. `wr_valid` and `wr_addr` depend on the current input word and on registered state only, never on `wr_ready`. A held word therefore keeps its address until it is accepted. The control and settings pins are plain levels or pulses. The markers and the broken flag qualify the word they arrive with. A field is at least two words long, so `pix_sof` and `pix_eof` never share a word.

Top module: `field_addr_seq`

## Requirements
- R1: After reset or a `cfg_commit` pulse, the next written field starts at `cfg_base`.
- R2: Each later field that completes without reuse moves the next start by `cfg_buf_ofs`. After slot number `cfg_nbuf`-1, the next start returns to `cfg_base`.
- R3: `cfg_run` bit 0 enables running and bit 1 selects single-shot. Values 0 and 2 write nothing and give no done pulse, while `pix_ready` stays high. Value 1 is free-running.
- R4: With `cfg_run`=3, writing stops after `cfg_nbuf` buffers have completed. A `buf_ack` pulse resumes writing, and the next field starts at `cfg_base`.
- R5: The run mode is taken at a field's first word. Clearing `cfg_run` during a field lets that field finish. The following field is not written.
- R6: The first word of a field is written at the slot start. Each further accepted word of a line is written one address higher. Each new line starts `cfg_line_ofs` past the previous line start.
- R7: Words with a zero-based in-line index of `cfg_width` or more give no write.
- R8: Lines with a zero-based index of `cfg_height` or more give no write and no line pulse.
- R9: With `cfg_ovr_broken`=1, a field that ends with `pix_broken` set on its last word, or with fewer than `cfg_height` lines, gives no done pulse, and the next field reuses its start address. With `cfg_ovr_broken`=0, such fields complete normally.
- R10: A `cfg_nbuf` of 0 behaves as 1, so every field starts at `cfg_base`.
- R11: `field_done` pulses for one cycle after the edge that accepts a completing field's last word, with `done_addr` equal to that field's start. `line_done` pulses after the edge that accepts a written line's last word, with `line_idx` equal to that line's index.
- R12: While `wr_valid` is high and `wr_ready` is low, `pix_ready` is low and the write address does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_run | input | 2 | Run mode: bit 0 run, bit 1 single-shot |
| cfg_commit | input | 1 | Pulse: restart the ring at the base and clear the single-shot hold |
| cfg_nbuf | input | NW | Number of buffer slots (0 treated as 1) |
| cfg_base | input | AW | Word address of slot 0 |
| cfg_buf_ofs | input | AW | Stride between slot starts, in words |
| cfg_line_ofs | input | AW | Stride between line starts, in words |
| cfg_width | input | WW | Words kept per line |
| cfg_height | input | HW | Lines kept per field |
| cfg_ovr_broken | input | 1 | Reuse the slot of a broken or short field |
| buf_ack | input | 1 | Pulse: release the single-shot hold |
| pix_valid | input | 1 | Pixel word valid |
| pix_ready | output | 1 | Pixel word accepted when high with pix_valid |
| pix_sof | input | 1 | First word of a field |
| pix_eol | input | 1 | Last word of a line |
| pix_eof | input | 1 | Last word of a field |
| pix_broken | input | 1 | Field marked broken, qualified by pix_eof |
| wr_valid | output | 1 | Write request for the current word |
| wr_ready | input | 1 | Memory side accepts the write |
| wr_addr | output | AW | Word address of the write |
| field_done | output | 1 | One-cycle pulse: a buffer was completed |
| done_addr | output | AW | Start address of the completed buffer |
| line_done | output | 1 | One-cycle pulse: a kept line was completed |
| line_idx | output | HW | Zero-based index of the completed line |

## Verification
`wr_valid`, `wr_addr` and `pix_ready` are combinational from the current word and registered state. The bench drives each word at the falling edge and samples these outputs shortly afterwards, in the same cycle and before the word is accepted. `field_done`/`done_addr` and `line_done`/`line_idx` are registered once. They are checked at the falling edge right after the rising edge that accepted the last word of the field or line. The back-pressure test samples over several stalled cycles before releasing `wr_ready`.

// File: rtl/fwa_pkg.sv
package fwa_pkg;
  localparam int RUN_BIT = 0;
  localparam int SHOT_BIT = 1;

  function automatic logic [23:0] slot_count(input logic [23:0] n);
    return (n == 24'd0) ? 24'd1 : n;
  endfunction
endpackage

// File: rtl/fwa_slot_ctrl.sv
module fwa_slot_ctrl
  import fwa_pkg::*;
#(
  parameter int AW = 32,
  parameter int NW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_run,
  input  logic          cfg_commit,
  input  logic [NW-1:0] cfg_nbuf,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_buf_ofs,
  input  logic          buf_ack,
  input  logic          field_start,
  input  logic          field_end,
  input  logic          field_reuse,
  output logic          start_ok,
  output logic [AW-1:0] start_addr,
  output logic          field_done,
  output logic [AW-1:0] done_addr
);
  logic          restart_q;
  logic          hold_q;
  logic          cur_shot_q;
  logic [AW-1:0] next_addr_q, cur_addr_q;
  logic [NW-1:0] next_idx_q, cur_idx_q;
  logic [NW-1:0] start_idx, n_eff, idx_inc;
  logic          ring_last;

  assign start_ok   = cfg_run[RUN_BIT] & ~hold_q;
  assign start_addr = restart_q ? cfg_base : next_addr_q;
  assign start_idx  = restart_q ? '0 : next_idx_q;
  assign n_eff      = NW'(slot_count(24'(cfg_nbuf)));
  assign idx_inc    = cur_idx_q + NW'(1);
  assign ring_last  = idx_inc >= n_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      restart_q   <= 1'b1;
      hold_q      <= 1'b0;
      cur_shot_q  <= 1'b0;
      next_addr_q <= '0;
      next_idx_q  <= '0;
      cur_addr_q  <= '0;
      cur_idx_q   <= '0;
      field_done  <= 1'b0;
      done_addr   <= '0;
    end else begin
      field_done <= 1'b0;
      if (field_start) begin
        cur_addr_q <= start_addr;
        cur_idx_q  <= start_idx;
        cur_shot_q <= cfg_run[SHOT_BIT];
        restart_q  <= 1'b0;
      end
      if (field_end) begin
        if (field_reuse) begin
          next_addr_q <= cur_addr_q;
          next_idx_q  <= cur_idx_q;
        end else begin
          field_done  <= 1'b1;
          done_addr   <= cur_addr_q;
          next_idx_q  <= ring_last ? '0 : idx_inc;
          next_addr_q <= ring_last ? cfg_base : cur_addr_q + cfg_buf_ofs;
          if (ring_last && cur_shot_q) hold_q <= 1'b1;
        end
      end
      if (buf_ack && hold_q) begin
        hold_q    <= 1'b0;
        restart_q <= 1'b1;
      end
      if (cfg_commit) begin
        hold_q    <= 1'b0;
        restart_q <= 1'b1;
      end
    end
  end

  // R4
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(field_end && !field_reuse));

  // R9
  reuse_nodone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_end && field_reuse) |=> !field_done);

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_end && !field_reuse && !ring_last && !cfg_commit)
      |=> next_addr_q == done_addr + $past(cfg_buf_ofs));
endmodule

// File: rtl/fwa_raster.sv
module fwa_raster #(
  parameter int AW = 32,
  parameter int WW = 12,
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic          pix_sof,
  input  logic          pix_eol,
  input  logic          pix_eof,
  input  logic          pix_broken,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  input  logic          start_ok,
  input  logic [AW-1:0] start_addr,
  input  logic [WW-1:0] cfg_width,
  input  logic [HW-1:0] cfg_height,
  input  logic [AW-1:0] cfg_line_ofs,
  input  logic          cfg_ovr_broken,
  output logic          field_start,
  output logic          field_end,
  output logic          field_reuse,
  output logic          line_done,
  output logic [HW-1:0] line_idx
);
  logic          on_q, ovr_q;
  logic [HW-1:0] line_q, h_q;
  logic [WW-1:0] word_q, w_q;
  logic [AW-1:0] laddr_q, lofs_q;

  logic          act, in_crop, acc, ovr_c, short_f;
  logic [HW-1:0] cl, hc;
  logic [WW-1:0] cw, wc;
  logic [AW-1:0] la, lofs_c;
  logic [HW:0]   lines_seen;

  always_comb begin
    act    = pix_sof ? start_ok : on_q;
    cl     = pix_sof ? '0 : line_q;
    cw     = pix_sof ? '0 : word_q;
    la     = pix_sof ? start_addr : laddr_q;
    wc     = pix_sof ? cfg_width : w_q;
    hc     = pix_sof ? cfg_height : h_q;
    lofs_c = pix_sof ? cfg_line_ofs : lofs_q;
    ovr_c  = pix_sof ? cfg_ovr_broken : ovr_q;
  end

  assign in_crop     = (cw < wc) && (cl < hc);
  assign wr_valid    = pix_valid & act & in_crop;
  assign wr_addr     = la + AW'(cw);
  assign pix_ready   = ~wr_valid | wr_ready;
  assign acc         = pix_valid & pix_ready;
  assign field_start = acc & pix_sof & start_ok;
  assign field_end   = acc & pix_eof & on_q & ~pix_sof;
  assign lines_seen  = {1'b0, cl} + (HW+1)'(pix_eol);
  assign short_f     = lines_seen < {1'b0, hc};
  assign field_reuse = ovr_c & (pix_broken | short_f);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q      <= 1'b0;
      ovr_q     <= 1'b0;
      line_q    <= '0;
      h_q       <= '0;
      word_q    <= '0;
      w_q       <= '0;
      laddr_q   <= '0;
      lofs_q    <= '0;
      line_done <= 1'b0;
      line_idx  <= '0;
    end else begin
      line_done <= 1'b0;
      if (acc) begin
        if (pix_sof) begin
          on_q   <= start_ok;
          w_q    <= cfg_width;
          h_q    <= cfg_height;
          lofs_q <= cfg_line_ofs;
          ovr_q  <= cfg_ovr_broken;
        end
        if (pix_eol) begin
          line_q    <= (cl < hc) ? cl + HW'(1) : cl;
          word_q    <= '0;
          laddr_q   <= la + lofs_c;
          line_done <= act & (cl < hc);
          line_idx  <= cl;
        end else begin
          line_q  <= cl;
          word_q  <= (cw < wc) ? cw + WW'(1) : cw;
          laddr_q <= la;
        end
        if (pix_eof && !pix_sof) on_q <= 1'b0;
      end
    end
  end

  // R11
  line_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> line_idx < h_q);

  // R6
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_valid && !pix_eol && !pix_eof)
      |=> (!wr_valid || pix_sof || wr_addr == $past(wr_addr) + AW'(1)));

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && wr_valid && !wr_ready && !pix_sof)
      |=> (!pix_valid || pix_sof || wr_addr == $past(wr_addr)));
endmodule

// File: rtl/field_addr_seq.sv
module field_addr_seq #(
  parameter int AW = 32,
  parameter int NW = 24,
  parameter int WW = 12,
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_run,
  input  logic          cfg_commit,
  input  logic [NW-1:0] cfg_nbuf,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_buf_ofs,
  input  logic [AW-1:0] cfg_line_ofs,
  input  logic [WW-1:0] cfg_width,
  input  logic [HW-1:0] cfg_height,
  input  logic          cfg_ovr_broken,
  input  logic          buf_ack,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic          pix_sof,
  input  logic          pix_eol,
  input  logic          pix_eof,
  input  logic          pix_broken,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic          field_done,
  output logic [AW-1:0] done_addr,
  output logic          line_done,
  output logic [HW-1:0] line_idx
);
  logic          start_ok, field_start, field_end, field_reuse;
  logic [AW-1:0] start_addr;

  fwa_slot_ctrl #(.AW(AW), .NW(NW)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .cfg_run(cfg_run), .cfg_commit(cfg_commit), .cfg_nbuf(cfg_nbuf),
    .cfg_base(cfg_base), .cfg_buf_ofs(cfg_buf_ofs), .buf_ack(buf_ack),
    .field_start(field_start), .field_end(field_end), .field_reuse(field_reuse),
    .start_ok(start_ok), .start_addr(start_addr),
    .field_done(field_done), .done_addr(done_addr)
  );

  fwa_raster #(.AW(AW), .WW(WW), .HW(HW)) u_rast (
    .clk(clk), .rst_n(rst_n),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_sof(pix_sof),
    .pix_eol(pix_eol), .pix_eof(pix_eof), .pix_broken(pix_broken),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .start_ok(start_ok), .start_addr(start_addr),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_line_ofs(cfg_line_ofs), .cfg_ovr_broken(cfg_ovr_broken),
    .field_start(field_start), .field_end(field_end), .field_reuse(field_reuse),
    .line_done(line_done), .line_idx(line_idx)
  );

  // R11
  done_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_done |-> $past(field_end));
endmodule

// File: tb/sim_field_addr_seq.sv
`timescale 1ns/1ps
module sim_field_addr_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  cfg_run = 0;
  logic        cfg_commit = 0;
  logic [23:0] cfg_nbuf = 0;
  logic [31:0] cfg_base = 32'h1000, cfg_buf_ofs = 32'h100, cfg_line_ofs = 32'h10;
  logic [11:0] cfg_width = 4, cfg_height = 3;
  logic        cfg_ovr_broken = 0, buf_ack = 0;
  logic        pix_valid = 0, pix_sof = 0, pix_eol = 0, pix_eof = 0, pix_broken = 0;
  logic        wr_ready = 1;
  logic        pix_ready, wr_valid, field_done, line_done;
  logic [31:0] wr_addr, done_addr;
  logic [11:0] line_idx;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  field_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_commit(cfg_commit),
    .cfg_nbuf(cfg_nbuf), .cfg_base(cfg_base), .cfg_buf_ofs(cfg_buf_ofs),
    .cfg_line_ofs(cfg_line_ofs), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_ovr_broken(cfg_ovr_broken), .buf_ack(buf_ack),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_sof(pix_sof),
    .pix_eol(pix_eol), .pix_eof(pix_eof), .pix_broken(pix_broken),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .field_done(field_done), .done_addr(done_addr),
    .line_done(line_done), .line_idx(line_idx)
  );

  typedef struct packed {
    logic        commit;
    logic [1:0]  run;
    logic [23:0] nbuf;
    logic [11:0] w;
    logic [11:0] h;
    logic [7:0]  nl;
    logic [7:0]  nw;
    logic        brk;
    logic        ovr;
    logic        act;
    logic [31:0] start;
    logic        done;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd1, 24'd3, 12'd4, 12'd3, 8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 32'h1000, 1'b1},
    '{1'b0, 2'd1, 24'd3, 12'd4, 12'd3, 8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 32'h1100, 1'b1},
    '{1'b0, 2'd1, 24'd3, 12'd4, 12'd3, 8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 32'h1200, 1'b1},
    '{1'b0, 2'd1, 24'd3, 12'd4, 12'd3, 8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 32'h1000, 1'b1},
    '{1'b0, 2'd1, 24'd3, 12'd4, 12'd3, 8'd3, 8'd6, 1'b0, 1'b0, 1'b1, 32'h1100, 1'b1},
    '{1'b0, 2'd1, 24'd3, 12'd4, 12'd3, 8'd5, 8'd4, 1'b0, 1'b0, 1'b1, 32'h1200, 1'b1},
    '{1'b0, 2'd1, 24'd3, 12'd4, 12'd3, 8'd2, 8'd4, 1'b0, 1'b1, 1'b1, 32'h1000, 1'b0},
    '{1'b0, 2'd1, 24'd3, 12'd4, 12'd3, 8'd3, 8'd4, 1'b1, 1'b1, 1'b1, 32'h1000, 1'b0},
    '{1'b0, 2'd1, 24'd3, 12'd4, 12'd3, 8'd3, 8'd4, 1'b0, 1'b1, 1'b1, 32'h1000, 1'b1},
    '{1'b0, 2'd1, 24'd3, 12'd4, 12'd3, 8'd3, 8'd4, 1'b1, 1'b0, 1'b1, 32'h1100, 1'b1},
    '{1'b0, 2'd0, 24'd3, 12'd4, 12'd3, 8'd3, 8'd4, 1'b0, 1'b0, 1'b0, 32'h0,    1'b0},
    '{1'b0, 2'd2, 24'd3, 12'd4, 12'd3, 8'd3, 8'd4, 1'b0, 1'b0, 1'b0, 32'h0,    1'b0},
    '{1'b0, 2'd1, 24'd3, 12'd4, 12'd3, 8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 32'h1200, 1'b1},
    '{1'b1, 2'd1, 24'd0, 12'd4, 12'd3, 8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 32'h1000, 1'b1},
    '{1'b0, 2'd1, 24'd0, 12'd4, 12'd3, 8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 32'h1000, 1'b1},
    '{1'b1, 2'd3, 24'd2, 12'd4, 12'd3, 8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 32'h1000, 1'b1},
    '{1'b0, 2'd3, 24'd2, 12'd4, 12'd3, 8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 32'h1100, 1'b1},
    '{1'b0, 2'd3, 24'd2, 12'd4, 12'd3, 8'd3, 8'd4, 1'b0, 1'b0, 1'b0, 32'h0,    1'b0}
  };

  string tags [NV];

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_commit();
    @(negedge clk) cfg_commit = 1;
    @(negedge clk) cfg_commit = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk) buf_ack = 1;
    @(negedge clk) buf_ack = 0;
  endtask

  // Sends nl lines of nw words; checks writes, line pulses and the done pulse.
  task automatic send_field(input int nl, input int nw, input logic brk,
                            input logic act, input logic [31:0] start,
                            input logic exp_done, input logic stop_mid,
                            input string tag);
    logic ld_exp = 0;
    int   li_exp = 0;
    for (int l = 0; l < nl; l++) begin
      for (int w = 0; w < nw; w++) begin
        logic        ev;
        logic [31:0] ea;
        @(negedge clk);
        chk(line_done == ld_exp && (!ld_exp || line_idx == 12'(li_exp)),
            {tag, " R11 line pulse"}, {line_done, 19'd0, line_idx}, {ld_exp, 19'd0, 12'(li_exp)});
        if (stop_mid && l == 1 && w == 0) cfg_run = 0;
        pix_valid  = 1;
        pix_sof    = (l == 0 && w == 0);
        pix_eol    = (w == nw - 1);
        pix_eof    = (l == nl - 1 && w == nw - 1);
        pix_broken = pix_eof & brk;
        #1;
        ev = act && (l < int'(cfg_height_f)) && (w < int'(cfg_width_f));
        ea = start + 32'(l) * cfg_line_ofs + 32'(w);
        chk(wr_valid == ev && (!ev || wr_addr == ea) && pix_ready,
            {tag, " R6 R7 R8 write"}, ev ? wr_addr : {31'd0, wr_valid}, ev ? ea : {31'd0, ev});
        ld_exp = pix_eol && act && (l < int'(cfg_height_f));
        li_exp = l;
        @(posedge clk);
      end
    end
    @(negedge clk);
    pix_valid = 0; pix_sof = 0; pix_eol = 0; pix_eof = 0; pix_broken = 0;
    chk(line_done == ld_exp, {tag, " R11 last line pulse"}, {31'd0, line_done}, {31'd0, ld_exp});
    chk(field_done == exp_done && (!exp_done || done_addr == start),
        {tag, " R11 done"}, exp_done ? done_addr : {31'd0, field_done},
        exp_done ? start : {31'd0, exp_done});
  endtask

  logic [11:0] cfg_width_f, cfg_height_f;
  always_comb begin
    cfg_width_f  = cfg_width;
    cfg_height_f = cfg_height;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tags = '{"R1", "R2", "R2", "R2", "R7", "R8", "R9", "R9", "R9", "R9",
             "R3", "R3", "R3", "R10", "R10", "R4", "R4", "R4"};
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk(!wr_valid && pix_ready && !field_done && !line_done, "R1 reset state",
        {28'd0, wr_valid, pix_ready, field_done, line_done}, 32'h4);

    for (int i = 0; i < NV; i++) begin
      cfg_run        = TBL[i].run;
      cfg_nbuf       = TBL[i].nbuf;
      cfg_width      = TBL[i].w;
      cfg_height     = TBL[i].h;
      cfg_ovr_broken = TBL[i].ovr;
      if (TBL[i].commit) pulse_commit();
      send_field(int'(TBL[i].nl), int'(TBL[i].nw), TBL[i].brk, TBL[i].act,
                 TBL[i].start, TBL[i].done, 1'b0, tags[i]);
    end

    // R4: acknowledge releases the single-shot hold, restart at base
    pulse_ack();
    send_field(3, 4, 1'b0, 1'b1, 32'h1000, 1'b1, 1'b0, "R4 after ack");

    // R5: run cleared mid-field finishes the field, next one is dropped
    cfg_run = 1; cfg_nbuf = 3;
    pulse_commit();
    send_field(3, 4, 1'b0, 1'b1, 32'h1000, 1'b1, 1'b1, "R5 finish");
    send_field(3, 4, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, "R5 stopped");

    // R12: back-pressure holds the word and its address
    cfg_run = 1;
    pulse_commit();
    @(negedge clk);
    wr_ready = 0; pix_valid = 1; pix_sof = 1; pix_eol = 0; pix_eof = 0;
    #1;
    chk(wr_valid && !pix_ready && wr_addr == 32'h1000, "R12 stall first", wr_addr, 32'h1000);
    @(negedge clk);
    #1;
    chk(wr_valid && !pix_ready && wr_addr == 32'h1000, "R12 stall held", wr_addr, 32'h1000);
    @(negedge clk);
    wr_ready = 1;
    #1;
    chk(pix_ready && wr_addr == 32'h1000, "R12 release", wr_addr, 32'h1000);
    @(negedge clk);
    pix_sof = 0; pix_eol = 1; pix_eof = 1;
    #1;
    chk(wr_valid && wr_addr == 32'h1001, "R12 R6 next word", wr_addr, 32'h1001);
    @(negedge clk);
    pix_valid = 0; pix_eol = 0; pix_eof = 0;
    chk(line_done && line_idx == 0, "R11 R12 line", {31'd0, line_done}, 32'd1);
    // one line against height 3 with reuse off: completes normally
    chk(field_done && done_addr == 32'h1000, "R11 R12 done", done_addr, 32'h1000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule